// File: doc/BRIEF.md
# Power Domain Sequencer

This block steps one switchable power domain through a safe shutdown and a safe wake-up. Before the domain loses power, its bus interface has to stop taking traffic. The sequencer raises an idle request and waits for the interface to acknowledge it. It then waits for the interface to report that it is idle, and only after that does it open the power switch. Wake-up runs in the reverse order. The switch closes first, and once the power status shows the domain powered, the idle request is withdrawn. The sequencer then waits for both the acknowledge and the idle status to clear.

A one-cycle command pulse carries the requested state. The command is accepted only when the block is not busy and the requested state differs from the domain's current state. Every wait is bounded by a cycle limit. A domain can be built without a power switch (idle-only). In that case its on/off state is the inverse of its idle status. It can also be built without an idle handshake (switch-only), in which case only the switch is toggled.

Top module: `pwr_dom_seq`

## Requirements
- R1: Out of reset, idle_req_o is 0, sw_en_o is 1 (domain powered), and busy_o, done_o and err_o are 0.
- R2: A power-down command first sets idle_req_o to 1. The block then waits for ack_i to be 1, then for idle_i to be 1, then clears sw_en_o and waits for pwr_off_i to be 1. Each wait ends one clock after the awaited value appears. With responders that follow after delays of Da, Di and Dp cycles, done_o rises Da+Di+Dp+2 cycles after the accepting edge.
- R3: A power-up command first sets sw_en_o to 1 and waits for pwr_off_i to be 0. It then clears idle_req_o and waits for ack_i to be 0, then for idle_i to be 0. With the same responders, done_o rises after the same Da+Di+Dp+2 cycles.
- R4: pwr_off_i is active high: 1 means the domain is unpowered and 0 means it is powered. With a switch present, the current state is the inverse of pwr_off_i.
- R5: With HAS_SWITCH=0 the current state is the inverse of idle_i, sw_en_o never changes, and each transition is the handshake alone. done_o rises Da+Di+1 cycles after acceptance.
- R6: With HAS_IDLE_REQ=0, idle_req_o stays 0 and each transition only toggles sw_en_o. done_o rises Dp+1 cycles after acceptance.
- R7: If a wait does not see its expected value within TIMEOUT_CYCLES clock edges of entering that wait, err_o rises exactly TIMEOUT_CYCLES cycles after entry. busy_o then falls, done_o stays 0, and idle_req_o and sw_en_o keep their values.
- R8: A command whose requested state equals the current state does nothing: busy_o, done_o, err_o, idle_req_o and sw_en_o are all unchanged.
- R9: busy_o is 1 from the accepting edge until completion or error. A command that arrives while busy_o is 1 is ignored and does not change the running sequence or its timing.
- R10: done_o is a single-cycle pulse with busy_o low. err_o stays at 1 until the next accepted command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command pulse |
| cmd_on_i | input | 1 | Requested state: 1 powered, 0 off |
| ack_i | input | 1 | Bus interface acknowledge of the idle request |
| idle_i | input | 1 | Bus interface reports idle |
| pwr_off_i | input | 1 | Power status, 1 = domain unpowered |
| idle_req_o | output | 1 | Idle request to the bus interface |
| sw_en_o | output | 1 | Power switch enable, 1 = closed (powered) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky timeout error |

## Verification
The assertions check the orderings on every cycle. The switch opens only after idle was seen, and the idle request is withdrawn only once power is reported good. They also check that done is a single cycle that never coincides with busy or error, that the error holds until a command arrives, and that the wait counter stays within its limit. Some behaviours can only be shown by the bench's scenarios. These are the exact latencies across the sweep of responder delays, the exact cycle of a timeout, the idle-only and switch-only variants, and the silence of redundant or busy-time commands.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_IDL  = 2'd2,
        ST_PWR  = 2'd3
    } pds_state_e;

    typedef struct packed {
        pds_state_e state;
        logic       dir_on;
        logic       idle_req;
        logic       sw_en;
        logic       busy;
        logic       done;
        logic       err;
    } pds_regs_t;

endpackage

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = run && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (run && !expired)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R7

endmodule

// File: rtl/pds_domain_sense.sv
module pds_domain_sense
    import pds_pkg::*;
#(
    parameter bit HAS_SWITCH = 1'b1
) (
    input  pds_state_e state,
    input  logic       idle_req_q,
    input  logic       sw_en_q,
    input  logic       ack_i,
    input  logic       idle_i,
    input  logic       pwr_off_i,
    output logic       cur_on,
    output logic       step_ok
);
    generate
        if (HAS_SWITCH) begin : g_sw
            assign cur_on = !pwr_off_i;
        end else begin : g_noswitch
            assign cur_on = !idle_i;
        end
    endgenerate

    always_comb begin
        case (state)
            ST_ACK:  step_ok = (ack_i == idle_req_q);
            ST_IDL:  step_ok = (idle_i == idle_req_q);
            ST_PWR:  step_ok = (pwr_off_i == !sw_en_q);
            default: step_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
    import pds_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 10000,
    parameter bit HAS_SWITCH     = 1'b1,
    parameter bit HAS_IDLE_REQ   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid_i,
    input  logic cmd_on_i,
    input  logic ack_i,
    input  logic idle_i,
    input  logic pwr_off_i,
    output logic idle_req_o,
    output logic sw_en_o,
    output logic busy_o,
    output logic done_o,
    output logic err_o
);
    pds_regs_t r_d, r_q;
    logic cur_on, step_ok, expired, tmr_clear, tmr_run;

    pds_domain_sense #(.HAS_SWITCH(HAS_SWITCH)) u_sense (
        .state      (r_q.state),
        .idle_req_q (r_q.idle_req),
        .sw_en_q    (r_q.sw_en),
        .ack_i      (ack_i),
        .idle_i     (idle_i),
        .pwr_off_i  (pwr_off_i),
        .cur_on     (cur_on),
        .step_ok    (step_ok)
    );

    assign tmr_run   = (r_q.state != ST_IDLE);
    assign tmr_clear = (r_d.state != r_q.state) || !tmr_run;

    pds_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .run     (tmr_run),
        .expired (expired)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid_i && (cur_on != cmd_on_i)) begin
                    r_d.err    = 1'b0;
                    r_d.busy   = 1'b1;
                    r_d.dir_on = cmd_on_i;
                    if (!cmd_on_i) begin
                        if (HAS_IDLE_REQ) begin
                            r_d.idle_req = 1'b1;
                            r_d.state    = ST_ACK;
                        end else begin
                            r_d.sw_en = 1'b0;
                            r_d.state = ST_PWR;
                        end
                    end else begin
                        if (HAS_SWITCH) begin
                            r_d.sw_en = 1'b1;
                            r_d.state = ST_PWR;
                        end else begin
                            r_d.idle_req = 1'b0;
                            r_d.state    = ST_ACK;
                        end
                    end
                end
            end
            ST_ACK: begin
                if (step_ok)
                    r_d.state = ST_IDL;
            end
            ST_IDL: begin
                if (step_ok) begin
                    if (!r_q.dir_on && HAS_SWITCH) begin
                        r_d.sw_en = 1'b0;
                        r_d.state = ST_PWR;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.busy  = 1'b0;
                        r_d.done  = 1'b1;
                    end
                end
            end
            ST_PWR: begin
                if (step_ok) begin
                    if (r_q.dir_on && HAS_IDLE_REQ) begin
                        r_d.idle_req = 1'b0;
                        r_d.state    = ST_ACK;
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.busy  = 1'b0;
                        r_d.done  = 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (r_q.state != ST_IDLE && !step_ok && expired) begin
            r_d.state = ST_IDLE;
            r_d.busy  = 1'b0;
            r_d.err   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.dir_on   <= 1'b1;
            r_q.idle_req <= 1'b0;
            r_q.sw_en    <= 1'b1;
            r_q.busy     <= 1'b0;
            r_q.done     <= 1'b0;
            r_q.err      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle_req_o = r_q.idle_req;
    assign sw_en_o    = r_q.sw_en;
    assign busy_o     = r_q.busy;
    assign done_o     = r_q.done;
    assign err_o      = r_q.err;

    generate
        if (HAS_SWITCH && HAS_IDLE_REQ) begin : g_order_chk
            AST_OPEN_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(sw_en_o) |-> $past(idle_i)); // R2
            AST_UNIDLE_AFTER_POWER: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(idle_req_o) |-> !$past(pwr_off_i)); // R3
        end
        if (!HAS_IDLE_REQ) begin : g_noreq_chk
            AST_NO_IDLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
                !idle_req_o); // R6
        end
    endgenerate

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !err_o)); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !cmd_valid_i) |=> err_o); // R10
    AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(cmd_valid_i)); // R9
    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !busy_o); // R7

endmodule

// File: tb/pwr_dom_seq_tb.sv
module pds_resp_model (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle_req,
    input  logic       sw_en,
    input  logic [2:0] da,
    input  logic [2:0] di,
    input  logic [2:0] dp,
    input  logic       hold_ack,
    input  logic       hold_pwr,
    output logic       ack,
    output logic       idle,
    output logic       pwr_off
);
    logic [7:0] sr_a, sr_i, sr_p;
    assign ack     = sr_a[da - 3'd1];
    assign idle    = sr_i[di - 3'd1];
    assign pwr_off = sr_p[dp - 3'd1];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_a <= '0; sr_i <= '0; sr_p <= '0;
        end else begin
            if (!hold_ack) sr_a <= {sr_a[6:0], idle_req};
            sr_i <= {sr_i[6:0], ack};
            if (!hold_pwr) sr_p <= {sr_p[6:0], !sw_en};
        end
    end
endmodule

module pwr_dom_seq_tb;
    localparam int TO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [2:0] cv = '0, con = '0;
    logic [2:0] rq, se, bz, dn, er, ak, id, po;
    logic [2:0] ha = '0, hp = '0;
    logic [2:0] da [3];
    logic [2:0] di [3];
    logic [2:0] dp [3];

    int checks = 0;
    int failures = 0;

    pwr_dom_seq #(.TIMEOUT_CYCLES(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cv[0]), .cmd_on_i(con[0]),
        .ack_i(ak[0]), .idle_i(id[0]), .pwr_off_i(po[0]),
        .idle_req_o(rq[0]), .sw_en_o(se[0]), .busy_o(bz[0]), .done_o(dn[0]), .err_o(er[0]));

    pwr_dom_seq #(.TIMEOUT_CYCLES(TO), .HAS_SWITCH(1'b0)) u_dut_ionly (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cv[1]), .cmd_on_i(con[1]),
        .ack_i(ak[1]), .idle_i(id[1]), .pwr_off_i(po[1]),
        .idle_req_o(rq[1]), .sw_en_o(se[1]), .busy_o(bz[1]), .done_o(dn[1]), .err_o(er[1]));

    pwr_dom_seq #(.TIMEOUT_CYCLES(TO), .HAS_IDLE_REQ(1'b0)) u_dut_sonly (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cv[2]), .cmd_on_i(con[2]),
        .ack_i(ak[2]), .idle_i(id[2]), .pwr_off_i(po[2]),
        .idle_req_o(rq[2]), .sw_en_o(se[2]), .busy_o(bz[2]), .done_o(dn[2]), .err_o(er[2]));

    for (genvar g = 0; g < 3; g++) begin : g_resp
        pds_resp_model u_resp (
            .clk(clk), .rst_n(rst_n), .idle_req(rq[g]), .sw_en(se[g]),
            .da(da[g]), .di(di[g]), .dp(dp[g]), .hold_ack(ha[g]), .hold_pwr(hp[g]),
            .ack(ak[g]), .idle(id[g]), .pwr_off(po[g]));
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // issue a command and measure cycles until done
    task automatic run_seq(int k, bit on, int exp_lat, string req);
        int lat = 0;
        @(negedge clk); cv[k] = 1'b1; con[k] = on;
        @(negedge clk); cv[k] = 1'b0;
        chk({req, " busy after accept (R9)"}, int'(bz[k]), 1);
        while (!dn[k] && lat < 200) begin
            @(negedge clk); lat++;
        end
        chk({req, " latency"}, lat, exp_lat);
        chk({req, " busy low at done (R10)"}, int'(bz[k]), 0);
        chk({req, " err low at done"}, int'(er[k]), 0);
        if (k == 0 && !on) begin
            chk("R4 pwr_off high when off", int'(po[0]), 1);
            chk("R2 idle seen before done", int'(id[0]), 1);
        end
        if (k != 2) chk({req, " idle_req final"}, int'(rq[k]), int'(!on));
        if (k != 1) chk({req, " sw_en final"}, int'(se[k]), int'(on));
        else        chk("R5 sw_en untouched", int'(se[1]), 1);
        @(negedge clk);
        chk("R10 done single cycle", int'(dn[k]), 0);
        idle_cycles(12);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            da[k] = 3'd2; di[k] = 3'd3; dp[k] = 3'd3;
        end
        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(2);
        // R1 reset state
        for (int k = 0; k < 3; k++) begin
            chk("R1 idle_req reset", int'(rq[k]), 0);
            chk("R1 sw_en reset", int'(se[k]), 1);
            chk("R1 busy reset", int'(bz[k]), 0);
            chk("R1 done reset", int'(dn[k]), 0);
            chk("R1 err reset", int'(er[k]), 0);
        end

        // R8 redundant power-up on a powered domain
        @(negedge clk); cv[0] = 1'b1; con[0] = 1'b1;
        @(negedge clk); cv[0] = 1'b0;
        for (int c = 0; c < 5; c++) begin
            chk("R8 no busy", int'(bz[0]), 0);
            chk("R8 no done", int'(dn[0]), 0);
            chk("R8 sw_en unchanged", int'(se[0]), 1);
            chk("R8 idle_req unchanged", int'(rq[0]), 0);
            @(negedge clk);
        end

        // R2 R3 sweep over responder delays
        for (int a = 1; a <= 3; a++)
            for (int b = 1; b <= 3; b++)
                for (int p = 1; p <= 3; p++) begin
                    da[0] = 3'(a); di[0] = 3'(b); dp[0] = 3'(p);
                    idle_cycles(2);
                    run_seq(0, 1'b0, a + b + p + 2, "R2 power-down");
                    run_seq(0, 1'b1, a + b + p + 2, "R3 power-up");
                end

        // R9 command while busy is ignored
        da[0] = 3'd2; di[0] = 3'd2; dp[0] = 3'd2;
        idle_cycles(12);
        begin
            int lat = 0;
            @(negedge clk); cv[0] = 1'b1; con[0] = 1'b0;
            @(negedge clk); cv[0] = 1'b0;
            @(negedge clk); lat++;
            cv[0] = 1'b1; con[0] = 1'b1;
            @(negedge clk); lat++; cv[0] = 1'b0;
            while (!dn[0] && lat < 200) begin
                @(negedge clk); lat++;
            end
            chk("R9 busy-time command keeps timing", lat, 8);
            chk("R9 switch still opened", int'(se[0]), 0);
            chk("R9 idle_req still set", int'(rq[0]), 1);
            idle_cycles(12);
        end
        run_seq(0, 1'b1, 8, "R9 recover power-up");

        // R5 idle-only variant
        @(negedge clk); cv[1] = 1'b1; con[1] = 1'b1;
        @(negedge clk); cv[1] = 1'b0;
        chk("R5 redundant on ignored (R8)", int'(bz[1]), 0);
        idle_cycles(3);
        run_seq(1, 1'b0, 2 + 3 + 1, "R5 idle-only down");
        run_seq(1, 1'b1, 2 + 3 + 1, "R5 idle-only up");

        // R6 switch-only variant
        run_seq(2, 1'b0, 3 + 1, "R6 switch-only down");
        chk("R6 idle_req stays 0", int'(rq[2]), 0);
        run_seq(2, 1'b1, 3 + 1, "R6 switch-only up");

        // R7 timeout on acknowledge
        ha[0] = 1'b1;
        begin
            int lat = 0;
            @(negedge clk); cv[0] = 1'b1; con[0] = 1'b0;
            @(negedge clk); cv[0] = 1'b0;
            while (!er[0] && lat < 200) begin
                chk("R7 no done during stall", int'(dn[0]), 0);
                @(negedge clk); lat++;
            end
            chk("R7 ack timeout cycle", lat, TO);
            chk("R7 busy dropped", int'(bz[0]), 0);
            chk("R7 idle_req held", int'(rq[0]), 1);
            chk("R7 sw_en held", int'(se[0]), 1);
            idle_cycles(5);
            chk("R10 err sticky", int'(er[0]), 1);
        end
        ha[0] = 1'b0;
        idle_cycles(12);
        @(negedge clk); cv[0] = 1'b1; con[0] = 1'b0;
        @(negedge clk); cv[0] = 1'b0;
        chk("R10 err cleared on accept", int'(er[0]), 0);
        begin
            int lat = 0;
            while (!dn[0] && lat < 200) begin
                @(negedge clk); lat++;
            end
            chk("R7 retry completes", int'(dn[0]), 1);
            chk("R7 retry switch open", int'(se[0]), 0);
        end
        idle_cycles(12);

        // R7 timeout on power status during power-up
        hp[0] = 1'b1;
        begin
            int lat = 0;
            @(negedge clk); cv[0] = 1'b1; con[0] = 1'b1;
            @(negedge clk); cv[0] = 1'b0;
            while (!er[0] && lat < 200) begin
                @(negedge clk); lat++;
            end
            chk("R7 power timeout cycle", lat, TO);
            chk("R7 switch held closed", int'(se[0]), 1);
            chk("R7 idle_req not released", int'(rq[0]), 1);
        end
        hp[0] = 1'b0;
        idle_cycles(12);
        // domain now reports powered: redundant power-up must not clear err
        @(negedge clk); cv[0] = 1'b1; con[0] = 1'b1;
        @(negedge clk); cv[0] = 1'b0;
        idle_cycles(3);
        chk("R8 redundant command leaves err", int'(er[0]), 1);
        chk("R8 redundant command no busy", int'(bz[0]), 0);

        finish_run();
    end
endmodule